// File: doc/BRIEF.md
# Reset and Output Mute Sequencer

This block sequences the internal reset and the output mute of an audio converter datapath. It runs entirely on the master clock. A power-on reset or a soft-reset request raises the datapath reset. Once that reset is released, the mute signal stays high for a fixed number of sample periods. Each sample period is counted as the selected master-clock-to-sample-rate ratio in master-clock cycles, so no frame clock is needed to time the mute.

A soft reset is requested by a one-cycle pulse from the control interface whenever the reset register is addressed. It ends at the first of two events: the next register write strobe, or the end of a fixed hold of master-clock cycles. Either way, a full mute window follows. A new soft reset that arrives during a mute window restarts the window from its beginning. The serializer downstream applies the mute only at word boundaries, so the mute can safely fall on any master-clock edge.

Top module: `rst_mute_seq`

## Requirements
- R1: While `por_n` is low, `core_rst` and `mute` are both high, without waiting for a clock edge.
- R2: After `por_n` goes high, `core_rst` falls at the first rising edge of `mclk`.
- R3: After `core_rst` falls, `mute` stays high for exactly MUTE_SAMPLES × ratio cycles and then falls. The ratio is chosen by `ratio_sel`: 0→128, 1→192, 2→256, 3→384, 4→512, 5→768, and codes 6 and 7 give 256.
- R4: A `soft_rst` pulse sampled on an edge makes `core_rst` and `mute` high from that edge onward.
- R5: If no write strobe arrives, a soft reset keeps `core_rst` high for exactly SOFT_HOLD cycles, counting the edge that sampled `soft_rst`.
- R6: A `wr_stb` sampled k cycles after the `soft_rst` edge, with 1 ≤ k < SOFT_HOLD, releases `core_rst` on that edge. A `wr_stb` in the same cycle as `soft_rst` does not shorten the reset.
- R7: A soft reset that arrives during a mute window discards the remaining count. A full window then follows the new release.
- R8: The ratio is captured when `core_rst` is released. Changing `ratio_sel` during a mute window does not change its length.
- R9: A `wr_stb` that arrives outside a reset has no effect on `core_rst` or `mute`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | One-cycle soft-reset request from the control interface |
| wr_stb | input | 1 | One-cycle register write strobe from the control interface |
| ratio_sel | input | 3 | Master-clock-to-sample-rate ratio code |
| core_rst | output | 1 | Internal datapath reset, active high |
| mute | output | 1 | Output mute request to the serializer, active high |

## Verification
The bench builds the block with MUTE_SAMPLES set to 4 and SOFT_HOLD left at 4. With these values a mute window lasts at most 3072 cycles, short enough to sweep all eight ratio codes against every write-strobe position inside the soft-reset hold. The same short windows also leave room to check interrupted windows, ratio changes during a window, and strobes that arrive in the same cycle as the reset request or while the block is idle.

// File: rtl/rst_mute_seq.sv
module rst_mute_seq #(
  parameter int MUTE_SAMPLES = 32,
  parameter int SOFT_HOLD    = 4
) (
  input  logic       mclk,
  input  logic       por_n,
  input  logic       soft_rst,
  input  logic       wr_stb,
  input  logic [2:0] ratio_sel,
  output logic       core_rst,
  output logic       mute
);

  localparam int MAX_RATIO = 768;
  localparam int CW = $clog2(MUTE_SAMPLES * MAX_RATIO + 1);
  localparam int HW = $clog2(SOFT_HOLD + 1);

  logic [HW-1:0] hold_cnt;
  logic [CW-1:0] mute_cnt;
  logic [CW-1:0] mute_load;
  logic [9:0]    ratio;
  logic          release_now;

  always_comb begin
    case (ratio_sel)
      3'd0:    ratio = 10'd128;
      3'd1:    ratio = 10'd192;
      3'd3:    ratio = 10'd384;
      3'd4:    ratio = 10'd512;
      3'd5:    ratio = 10'd768;
      default: ratio = 10'd256;
    endcase
  end

  assign mute_load   = CW'(MUTE_SAMPLES * int'(ratio));
  assign release_now = core_rst && (wr_stb || hold_cnt == '0 || hold_cnt == HW'(SOFT_HOLD));
  assign mute        = core_rst || (mute_cnt != '0);

  always_ff @(posedge mclk or negedge por_n) begin
    if (!por_n) begin
      core_rst <= 1'b1;
      hold_cnt <= '0;
      mute_cnt <= '0;
    end else if (soft_rst) begin
      core_rst <= 1'b1;
      hold_cnt <= HW'(1);
    end else if (release_now) begin
      core_rst <= 1'b0;
      hold_cnt <= '0;
      mute_cnt <= mute_load;
    end else if (core_rst) begin
      hold_cnt <= hold_cnt + HW'(1);
    end else if (mute_cnt != '0) begin
      mute_cnt <= mute_cnt - CW'(1);
    end
  end

endmodule

// File: rtl/rst_mute_seq_chk.sv
module rst_mute_seq_chk #(
  parameter int SOFT_HOLD = 4
) (
  input logic mclk,
  input logic por_n,
  input logic soft_rst,
  input logic wr_stb,
  input logic core_rst,
  input logic mute
);

  int run_len;

  always_ff @(posedge mclk or negedge por_n) begin
    if (!por_n)        run_len <= 0;
    else if (soft_rst) run_len <= 1;
    else if (core_rst) run_len <= run_len + 1;
    else               run_len <= 0;
  end

  a_r4_soft_enters_reset: assert property (@(posedge mclk) disable iff (!por_n)
    soft_rst |=> (core_rst && mute));

  a_r5_hold_bounded: assert property (@(posedge mclk) disable iff (!por_n)
    core_rst |-> (run_len <= SOFT_HOLD));

  a_r6_write_releases: assert property (@(posedge mclk) disable iff (!por_n)
    (core_rst && !soft_rst && wr_stb) |=> !core_rst);

  a_r9_no_spurious_reset: assert property (@(posedge mclk) disable iff (!por_n)
    (!core_rst && !soft_rst) |=> !core_rst);

  a_r3_mute_covers_release: assert property (@(posedge mclk) disable iff (!por_n)
    $fell(core_rst) |-> mute);

  a_r7_mute_rises_with_reset: assert property (@(posedge mclk) disable iff (!por_n)
    $rose(mute) |-> core_rst);

endmodule

bind rst_mute_seq rst_mute_seq_chk #(.SOFT_HOLD(SOFT_HOLD)) chk_i (
  .mclk(mclk), .por_n(por_n), .soft_rst(soft_rst), .wr_stb(wr_stb),
  .core_rst(core_rst), .mute(mute)
);

// File: tb/rst_mute_seq_tb_top.sv
`timescale 1ns/1ps
module rst_mute_seq_tb_top;

  localparam int MS = 4;
  localparam int SH = 4;

  logic       mclk = 1'b0;
  logic       por_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       wr_stb = 1'b0;
  logic [2:0] ratio_sel = 3'd0;
  logic       core_rst;
  logic       mute;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 mclk = ~mclk;

  rst_mute_seq #(.MUTE_SAMPLES(MS), .SOFT_HOLD(SH)) dut_i (
    .mclk(mclk), .por_n(por_n), .soft_rst(soft_rst), .wr_stb(wr_stb),
    .ratio_sel(ratio_sel), .core_rst(core_rst), .mute(mute)
  );

  function automatic int ratio_of(input int s);
    case (s)
      0: return 128; 1: return 192; 3: return 384;
      4: return 512; 5: return 768; default: return 256;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_mute(output int ml);
    ml = 0;
    while (mute && ml < 4000) begin
      ml++;
      @(negedge mclk);
    end
  endtask

  task automatic run_soft(input int k, input int sel, input int new_sel, input string req);
    int rl = 0;
    int ml;
    ratio_sel = 3'(sel);
    soft_rst = 1'b1;
    @(negedge mclk);
    soft_rst = 1'b0;
    while (core_rst && rl < 20) begin
      rl++;
      wr_stb = (k > 0 && rl == k);
      @(negedge mclk);
    end
    wr_stb = 1'b0;
    ratio_sel = 3'(new_sel);
    count_mute(ml);
    check({req, " reset length"}, rl, (k > 0) ? k : SH);
    check({req, " mute length"}, ml, MS * ratio_of(sel));
  endtask

  initial begin
    int ml;
    @(negedge mclk);
    check("R1 core_rst in por", int'(core_rst), 1);
    check("R1 mute in por", int'(mute), 1);
    por_n = 1'b1;
    ratio_sel = 3'd2;
    @(negedge mclk);
    check("R2 core_rst after por", int'(core_rst), 0);
    count_mute(ml);
    check("R2/R3 por mute length", ml, MS * 256);

    for (int s = 0; s < 8; s++)
      for (int k = 0; k < SH; k++)
        run_soft(k, s, s, (k == 0) ? "R3/R5" : "R3/R6");

    // R6: strobe together with the reset request must not shorten it
    ratio_sel = 3'd0;
    soft_rst = 1'b1; wr_stb = 1'b1;
    @(negedge mclk);
    soft_rst = 1'b0; wr_stb = 1'b0;
    begin
      int rl = 0;
      while (core_rst && rl < 20) begin rl++; @(negedge mclk); end
      check("R6 same-cycle strobe length", rl, SH);
    end
    count_mute(ml);

    // R8: ratio change mid-window
    run_soft(0, 1, 5, "R8");
    run_soft(0, 5, 0, "R8");

    // R7: restart during mute
    run_soft(2, 4, 4, "R7 first");
    ratio_sel = 3'd0;
    soft_rst = 1'b1;
    @(negedge mclk);
    soft_rst = 1'b0;
    repeat (SH) @(negedge mclk);
    repeat (100) @(negedge mclk);
    check("R7 mid mute", int'(mute), 1);
    run_soft(0, 3, 3, "R7 restart");

    // R4 and R9
    @(negedge mclk);
    wr_stb = 1'b1;
    @(negedge mclk);
    wr_stb = 1'b0;
    check("R9 core_rst idle strobe", int'(core_rst), 0);
    check("R9 mute idle strobe", int'(mute), 0);
    soft_rst = 1'b1;
    @(negedge mclk);
    soft_rst = 1'b0;
    check("R4 core_rst", int'(core_rst), 1);
    check("R4 mute", int'(mute), 1);
    repeat (SH) @(negedge mclk);
    count_mute(ml);

    // R1 asynchronous entry
    #1 por_n = 1'b0;
    #1;
    check("R1 async core_rst", int'(core_rst), 1);
    check("R1 async mute", int'(mute), 1);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge mclk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule